// File: doc/BRIEF.md
# Watchdog Counter with Deferred Standby

This block is an up-counting watchdog on a small CPU register bus. The counter advances on a prescaled tick. The tick comes from one of two raw strobes: a fast system-clock strobe divided by `SYS_DIV`, or a slow subclock strobe divided by `SUB_DIV`. When the counter wraps from all-ones to zero while the watchdog is enabled, the block emits a one-cycle internal reset pulse and sets a sticky status flag. Software keeps the watchdog alive by rewriting the counter, and it can read or write the counter at any time.

A separate standby bit can stop the counter's clock to save power. It has an interlock. A standby request (writing 0) made while the watchdog is enabled is stored and reads back at once, but counting and reset generation carry on. The request takes effect only after software clears the enable. While stopped, the counter and the prescaler both hold their values.

Register map (2-bit word address, `CNT_W`-bit data): address 0 is control/status, address 1 is the counter, address 2 is the standby register, and address 3 reads zero. Reads are combinational from `busAddr`.

Top module: `wdt_standby_top`

## Requirements
- R1: After reset the counter reads 0, control/status reads 0 (enable 0, source select 0, flag 0), the standby register reads 1 and `wdtReset` is low.
- R2: A bus write to address 1 loads the counter on the next clock edge, and reading address 1 returns the counter value.
- R3: With control bit 1 at 0, the counter increments once per `SYS_DIV` cycles with `sysTick` high, and `subTick` is ignored. With control bit 1 at 1, it increments once per `SUB_DIV` cycles with `subTick` high, and `sysTick` is ignored. Changing the select clears the prescaler.
- R4: With enable (control bit 0) at 1, a tick that takes the counter from all-ones to 0 drives `wdtReset` high for exactly one cycle and sets the flag (control bit `CNT_W-1`).
- R5: The flag stays set until a control write carries 0 in bit `CNT_W-1`. A control write with 1 in that bit leaves it unchanged.
- R6: With enable at 0 the counter still wraps to 0, but `wdtReset` stays low and the flag stays clear.
- R7: Writing 0 to standby bit 0 while enable is 0 freezes both the counter and the prescaler against further strobes.
- R8: Writing 0 to standby bit 0 while enable is 1 reads back as 0 at once, while counting and reset pulses continue.
- R9: A stored standby 0 takes effect when software later writes enable to 0, and the counter then freezes.
- R10: Writing 1 to standby bit 0 resumes counting from the frozen counter and prescaler state.
- R11: A counter write in the same cycle as a counter tick wins, and that increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Register word address |
| busWrData | input | CNT_W | Write data |
| busRdData | output | CNT_W | Read data for `busAddr` |
| sysTick | input | 1 | System-clock strobe, one cycle per pulse |
| subTick | input | 1 | Subclock strobe, one cycle per pulse |
| wdtReset | output | 1 | One-cycle internal reset pulse on wrap |

## Verification
On every cycle, the assertions check the following:
- the counter holds when neither a load nor a tick is present;
- a load wins over a tick;
- the reset pulse lasts one cycle, coincides with a zero count and never occurs when disarmed;
- the flag rises only on an armed wrap;
- a stopped block produces no tick;
- a standby request made while enabled is stored but does not stop the clock.

Only the bench scenarios can show the divider ratios per source, that the unselected strobe is ignored, and that the prescaler phase is frozen and later resumed across standby. They also show the full deferred sequence: the request is stored, counting continues, then the clock stops on disabling and restarts on release.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Register word addresses
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_STBY = 2'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntLoad;  // bus write to counter this cycle
    logic cntTick;  // prescaled tick this cycle
    logic rstArm;   // watchdog enabled: wrap raises reset
  } ctrlStrobes_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int SYS_DIV = 8192,
  parameter int SUB_DIV = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWr,
  input  logic [1:0]   regAddr,
  input  logic         wrEnBit,
  input  logic         wrSelBit,
  input  logic         wrFlagBit,
  input  logic         wrStbyBit,
  input  logic         sysTick,
  input  logic         subTick,
  input  logic         wrapEvt,
  output ctrlStrobes_t strb,
  output logic         enable,
  output logic         srcSel,
  output logic         rstFlag,
  output logic         stbyBit
);
  localparam int MAX_DIV = (SYS_DIV > SUB_DIV) ? SYS_DIV : SUB_DIV;
  localparam int PW      = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;
  localparam logic [PW-1:0] SYS_LIM = PW'(SYS_DIV - 1);
  localparam logic [PW-1:0] SUB_LIM = PW'(SUB_DIV - 1);

  logic [PW-1:0] prescCnt;
  logic [PW-1:0] prescLim;
  logic          ctrlWr, stbyWr, selChange, rawTick, gated, prescEnd;

  assign ctrlWr    = regWr && (regAddr == ADDR_CTRL);
  assign stbyWr    = regWr && (regAddr == ADDR_STBY);
  assign selChange = ctrlWr && (wrSelBit != srcSel);
  assign rawTick   = srcSel ? subTick : sysTick;
  assign prescLim  = srcSel ? SUB_LIM : SYS_LIM;
  assign prescEnd  = (prescCnt == prescLim);
  // Standby only bites once the watchdog enable is off
  assign gated     = !stbyBit && !enable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable  <= 1'b0;
      srcSel  <= 1'b0;
      rstFlag <= 1'b0;
      stbyBit <= 1'b1;
    end else begin
      if (ctrlWr) begin
        enable <= wrEnBit;
        srcSel <= wrSelBit;
      end
      if (wrapEvt && enable)
        rstFlag <= 1'b1;
      else if (ctrlWr && !wrFlagBit)
        rstFlag <= 1'b0;
      if (stbyWr)
        stbyBit <= wrStbyBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      prescCnt <= '0;
    else if (selChange)
      prescCnt <= '0;
    else if (rawTick && !gated)
      prescCnt <= prescEnd ? '0 : prescCnt + 1'b1;
  end

  always_comb begin
    strb.cntLoad = regWr && (regAddr == ADDR_CNT);
    strb.cntTick = rawTick && !gated && prescEnd && !selChange;
    strb.rstArm  = enable;
  end

  // R7, R9: a stopped block never ticks
  p_gate_blocks_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!stbyBit && !enable) |-> !strb.cntTick);
  // R4: an armed wrap sets the flag
  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrapEvt && enable) |=> rstFlag);
  // R5: the flag rises only from an armed wrap
  p_flag_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstFlag) |-> $past(wrapEvt && enable));
  // R8: a standby request while enabled is stored but does not stop the clock
  p_deferred_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stbyWr && !wrStbyBit && enable && !ctrlWr) |=> (!stbyBit && !gated));
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             wrapEvt,
  output logic             wdtRst
);
  // A load in the same cycle suppresses the wrap
  assign wrapEvt = strb.cntTick && !strb.cntLoad && (&count);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      wdtRst <= 1'b0;
    end else begin
      if (strb.cntLoad)
        count <= wrData;
      else if (strb.cntTick)
        count <= count + 1'b1;
      wdtRst <= wrapEvt && strb.rstArm;
    end
  end

  // R7: no load and no tick keeps the count
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cntLoad && !strb.cntTick) |=> $stable(count));
  // R11, R2: a load wins over a tick
  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntLoad |=> (count == $past(wrData)));
  // R4: the pulse lasts one cycle
  p_pulse_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    wdtRst |=> !wdtRst);
  // R4: the pulse coincides with a zero count
  p_pulse_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    wdtRst |-> (count == '0));
  // R6: a disarmed wrap raises no pulse
  p_no_pulse_unarmed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrapEvt && !strb.rstArm) |=> !wdtRst);
endmodule

// File: rtl/wdt_standby_top.sv
module wdt_standby_top
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int SYS_DIV = 8192,
  parameter int SUB_DIV = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic [1:0]       busAddr,
  input  logic [CNT_W-1:0] busWrData,
  output logic [CNT_W-1:0] busRdData,
  input  logic             sysTick,
  input  logic             subTick,
  output logic             wdtReset
);
  localparam int FLAG_BIT = CNT_W - 1;

  ctrlStrobes_t     strb;
  logic [CNT_W-1:0] count;
  logic             wrapEvt, enable, srcSel, rstFlag, stbyBit;

  wdt_ctrl #(.SYS_DIV(SYS_DIV), .SUB_DIV(SUB_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(busWrEn), .regAddr(busAddr),
    .wrEnBit(busWrData[0]), .wrSelBit(busWrData[1]),
    .wrFlagBit(busWrData[FLAG_BIT]), .wrStbyBit(busWrData[0]),
    .sysTick(sysTick), .subTick(subTick), .wrapEvt(wrapEvt),
    .strb(strb), .enable(enable), .srcSel(srcSel),
    .rstFlag(rstFlag), .stbyBit(stbyBit)
  );

  wdt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData),
    .count(count), .wrapEvt(wrapEvt), .wdtRst(wdtReset)
  );

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_CTRL: begin
        busRdData[FLAG_BIT] = rstFlag;
        busRdData[1]        = srcSel;
        busRdData[0]        = enable;
      end
      ADDR_CNT:  busRdData    = count;
      ADDR_STBY: busRdData[0] = stbyBit;
      default:   busRdData    = '0;
    endcase
  end
endmodule

// File: tb/wdt_standby_top_tb.sv
module wdt_standby_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWrEn = 1'b0;
  logic [1:0]   busAddr = 2'd0;
  logic [W-1:0] busWrData = '0;
  logic [W-1:0] busRdData;
  logic         sysTick = 1'b0;
  logic         subTick = 1'b0;
  logic         wdtReset;

  int checks = 0;
  int errors = 0;
  int pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_standby_top #(.CNT_W(W), .SYS_DIV(4), .SUB_DIV(2)) u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .sysTick(sysTick), .subTick(subTick), .wdtReset(wdtReset)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; busWrEn = 1'b0; sysTick = 1'b0; subTick = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    pulses = 0;
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  // Each strobe lasts one cycle; wdtReset is sampled after the edge that used it
  task automatic strobes(input bit useSub, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (useSub) subTick = 1'b1; else sysTick = 1'b1;
      @(negedge clk);
      subTick = 1'b0; sysTick = 1'b0;
      if (wdtReset) pulses++;
    end
  endtask

  task automatic expectCount(input string req, input int exp);
    logic [W-1:0] d;
    busRead(2'd1, d);
    check(d == W'(exp), req, d, exp);
  endtask

  task automatic testReset();
    logic [W-1:0] d;
    doReset();
    busRead(2'd0, d); check(d == 8'h00, "R1 ctrl", d, 0);
    busRead(2'd2, d); check(d == 8'h01, "R1 standby", d, 1);
    expectCount("R1 count", 0);
    check(wdtReset == 1'b0, "R1 wdtReset", wdtReset, 0);
  endtask

  task automatic testSources();
    doReset();
    strobes(0, 8);  expectCount("R3 sys div", 2);
    strobes(1, 6);  expectCount("R3 sub ignored", 2);
    busWrite(2'd0, 8'h02);
    strobes(1, 4);  expectCount("R3 sub div", 4);
    strobes(0, 8);  expectCount("R3 sys ignored", 4);
  endtask

  task automatic testWriteAndPriority();
    doReset();
    busWrite(2'd1, 8'hA5); expectCount("R2 load", 8'hA5);
    doReset();
    strobes(0, 3);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 2'd1; busWrData = 8'h10; sysTick = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; sysTick = 1'b0;
    expectCount("R11 write wins", 8'h10);
    strobes(0, 4); expectCount("R11 after", 8'h11);
  endtask

  task automatic testArmedWrap();
    logic [W-1:0] d;
    doReset();
    busWrite(2'd0, 8'h01);
    busWrite(2'd1, 8'hFE);
    strobes(0, 8);
    expectCount("R4 wrapped", 0);
    check(pulses == 1, "R4 pulse count", pulses, 1);
    check(wdtReset == 1'b0, "R4 pulse ended", wdtReset, 0);
    busRead(2'd0, d); check(d == 8'h81, "R4 flag set", d, 8'h81);
    busWrite(2'd0, 8'h81);
    busRead(2'd0, d); check(d == 8'h81, "R5 write 1 keeps", d, 8'h81);
    busWrite(2'd0, 8'h01);
    busRead(2'd0, d); check(d == 8'h01, "R5 write 0 clears", d, 8'h01);
  endtask

  task automatic testDisarmedWrap();
    logic [W-1:0] d;
    doReset();
    busWrite(2'd1, 8'hFF);
    strobes(0, 4);
    expectCount("R6 wrapped", 0);
    check(pulses == 0, "R6 no pulse", pulses, 0);
    busRead(2'd0, d); check(d == 8'h00, "R6 no flag", d, 0);
  endtask

  task automatic testStandby();
    logic [W-1:0] d;
    doReset();
    strobes(0, 3);
    busWrite(2'd2, 8'h00);
    strobes(0, 8);
    expectCount("R7 frozen", 0);
    busRead(2'd2, d); check(d == 8'h00, "R7 standby reads 0", d, 0);
    busWrite(2'd2, 8'h01);
    strobes(0, 1);
    expectCount("R10 resume keeps phase", 1);
  endtask

  task automatic testDeferred();
    logic [W-1:0] d;
    doReset();
    busWrite(2'd0, 8'h01);
    busWrite(2'd2, 8'h00);
    busRead(2'd2, d); check(d == 8'h00, "R8 stored", d, 0);
    strobes(0, 4);   expectCount("R8 still counts", 1);
    busWrite(2'd1, 8'hFF);
    strobes(0, 4);
    check(pulses == 1, "R8 still resets", pulses, 1);
    busWrite(2'd0, 8'h00);
    busRead(2'd0, d); check(d == 8'h00, "R5 cleared", d, 0);
    strobes(0, 8);   expectCount("R9 frozen after disable", 0);
    busWrite(2'd2, 8'h01);
    strobes(0, 4);   expectCount("R10 released", 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testSources();
    testWriteAndPriority();
    testArmedWrap();
    testDisarmedWrap();
    testStandby();
    testDeferred();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule